// File: doc/BRIEF.md
# Interleaved Bank Address Mapper with Open-Row Classification

This block takes a word address and splits it into a bank index, a row index and a column offset for a memory assembled from a power-of-two number of banks. Three layouts can be selected. Plain interleaving places consecutive words in consecutive banks. Swizzled interleaving folds the low row bits into the bank bits with XOR. Block layout gives each bank one contiguous address range.

The block also keeps one open-row record per bank. Each accepted request is labelled as a hit, a miss or a conflict against that record, and the record then takes the request's row. A scheduler downstream uses the label to decide whether the row must be opened or swapped.

Requests enter through a valid/ready handshake. The decoded result leaves one cycle later from a single output register, which holds its value while the consumer stalls.

Top module: `bank_mapper`

## Requirements
- R1: With `mode`=0 (spread), for the default of 4 banks and 16-word rows: bank = addr[1:0], column = addr[5:2], row = addr[15:6]. Addresses 32, 33 and 34 go to banks 0, 1 and 0 in a 2-bank view, and to banks 0, 1 and 2 in the default 4-bank configuration.
- R2: With `mode`=1 (swizzle): bank = addr[1:0] XOR addr[7:6], which is the lowest two row bits. Column and row are the same as in R1.
- R3: With `mode`=2 or 3 (block): bank = addr[15:14], row = addr[13:4], column = addr[3:0].
- R4: `out_kind` is 0 for a miss, 1 for a hit and 2 for a conflict. The value 3 never appears. A miss is reported when the bank holds no valid open row.
- R5: A request whose bank holds a valid open row is a hit when that row equals the request row, and a conflict otherwise.
- R6: Every accepted request makes its row the open row of its bank. The request accepted in the next cycle already sees that update.
- R7: Synchronous `rst` invalidates every open row and clears `out_valid`.
- R8: A request accepted at a clock edge appears on the outputs after that edge, so the latency is one cycle. With `out_ready` held high, one request is accepted per cycle.
- R9: `req_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold their values and no request is accepted.
- R10: `mode` must stay constant while a request is waiting, that is while `req_valid` is high and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Layout select: 0 spread, 1 swizzle, 2/3 block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W (16) | Word address |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_bank | output | BANK_W (2) | Bank index |
| out_row | output | ROW_W (10) | Row index |
| out_col | output | COL_W (4) | Column offset |
| out_kind | output | 2 | 0 miss, 1 hit, 2 conflict |

## Verification
The hardest case to reach is a run of back-to-back requests to one bank in which the classification of each request depends on the open-row update made in the same cycle the previous request was accepted. The stimulus covers this in three ways:
- Full-rate streams that alternate between two rows of a single bank.
- The same address pair sent in swizzle mode, where it spreads across two banks and should give only hits after two misses.
- A stall of the output stage with a second request waiting, which checks that the waiting request is neither lost nor classified twice.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    typedef enum logic [1:0] {
        MAP_SPREAD  = 2'd0,
        MAP_SWIZZLE = 2'd1,
        MAP_BLOCK   = 2'd2,
        MAP_BLOCK_B = 2'd3
    } map_mode_e;

    typedef enum logic [1:0] {
        ACC_MISS     = 2'd0,
        ACC_HIT      = 2'd1,
        ACC_CONFLICT = 2'd2,
        ACC_RSVD     = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/addr_split.sv
module addr_split
    import bank_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 2,
    parameter int COL_W  = 4,
    localparam int ROW_W = ADDR_W - BANK_W - COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        mode,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);

    logic [BANK_W-1:0] lo_bank;
    logic [ROW_W-1:0]  lo_row;
    logic [COL_W-1:0]  lo_col;
    logic [BANK_W-1:0] fold;

    // interleaved split {row, col, bank}
    assign lo_bank = addr[BANK_W-1:0];
    assign lo_col  = addr[BANK_W +: COL_W];
    assign lo_row  = addr[BANK_W+COL_W +: ROW_W];

    // fold width chosen by how many row bits exist
    generate
        if (ROW_W >= BANK_W) begin : g_fold_full
            assign fold = lo_row[BANK_W-1:0];
        end else begin : g_fold_part
            assign fold = {{(BANK_W-ROW_W){1'b0}}, lo_row};
        end
    endgenerate

    always_comb begin
        unique case (map_mode_e'(mode))
            MAP_SPREAD: begin
                bank = lo_bank;
                row  = lo_row;
                col  = lo_col;
            end
            MAP_SWIZZLE: begin
                bank = lo_bank ^ fold;
                row  = lo_row;
                col  = lo_col;
            end
            default: begin
                // block split {bank, row, col}
                bank = addr[ADDR_W-1 -: BANK_W];
                row  = addr[COL_W +: ROW_W];
                col  = addr[COL_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/open_row_table.sv
module open_row_table
    import bank_mapper_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int ROW_W = 10,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    input  logic              upd_en,
    output acc_kind_e         kind
);

    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
    } slot_t;

    slot_t slot_q [NBANK];
    slot_t slot_d [NBANK];
    slot_t cur;

    always_comb begin
        cur = slot_q[look_bank];
        if (!cur.valid) begin
            kind = ACC_MISS;
        end else if (cur.row == look_row) begin
            kind = ACC_HIT;
        end else begin
            kind = ACC_CONFLICT;
        end
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_slot
            always_comb begin
                slot_d[b] = slot_q[b];
                if (upd_en && (look_bank == BANK_W'(b))) begin
                    slot_d[b].valid = 1'b1;
                    slot_d[b].row   = look_row;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[b] <= '0;
                end else begin
                    slot_q[b] <= slot_d[b];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NBANK  = 4,
    parameter int COL_W  = 4,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int ROW_W  = ADDR_W - BANK_W - COL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BANK_W-1:0] out_bank,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col,
    output logic [1:0]        out_kind
);

    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        acc_kind_e         kind;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [BANK_W-1:0] dec_bank;
    logic [ROW_W-1:0]  dec_row;
    logic [COL_W-1:0]  dec_col;
    acc_kind_e         dec_kind;
    logic              take;

    addr_split #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_split (
        .addr (req_addr),
        .mode (mode),
        .bank (dec_bank),
        .row  (dec_row),
        .col  (dec_col)
    );

    open_row_table #(
        .NBANK (NBANK),
        .ROW_W (ROW_W)
    ) u_rows (
        .clk       (clk),
        .rst       (rst),
        .look_bank (dec_bank),
        .look_row  (dec_row),
        .upd_en    (take),
        .kind      (dec_kind)
    );

    assign req_ready = !stage_q.valid || out_ready;
    assign take      = req_valid && req_ready;

    always_comb begin
        stage_d = stage_q;
        if (take) begin
            stage_d.valid = 1'b1;
            stage_d.bank  = dec_bank;
            stage_d.row   = dec_row;
            stage_d.col   = dec_col;
            stage_d.kind  = dec_kind;
        end else if (out_ready) begin
            stage_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign out_bank  = stage_q.bank;
    assign out_row   = stage_q.row;
    assign out_col   = stage_q.col;
    assign out_kind  = stage_q.kind;

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
    parameter int ADDR_W = 16,
    parameter int NBANK  = 4,
    parameter int COL_W  = 4,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int ROW_W  = ADDR_W - BANK_W - COL_W
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BANK_W-1:0] out_bank,
    input logic [ROW_W-1:0]  out_row,
    input logic [COL_W-1:0]  out_col,
    input logic [1:0]        out_kind
);

    a_r7_reset_empty: assert property (@(posedge clk)
        rst |=> !out_valid);

    a_r4_no_rsvd_kind: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_kind != 2'd3);

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bank) && $stable(out_row)
             && $stable(out_col) && $stable(out_kind)));

    a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> req_ready);

    a_r1_spread_bank: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && mode == 2'd0) |=>
            out_bank == $past(req_addr[BANK_W-1:0]));

    a_r2_swizzle_bank: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && mode == 2'd1) |=>
            out_bank == ($past(req_addr[BANK_W-1:0])
                         ^ $past(req_addr[BANK_W+COL_W +: BANK_W])));

    a_r10_mode_steady: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> $stable(mode));

endmodule

bind bank_mapper bank_mapper_chk #(
    .ADDR_W (ADDR_W),
    .NBANK  (NBANK),
    .COL_W  (COL_W)
) u_chk (.*);

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;

    localparam int ADDR_W = 16;
    localparam int NBANK  = 4;
    localparam int COL_W  = 4;
    localparam int BANK_W = 2;
    localparam int ROW_W  = ADDR_W - BANK_W - COL_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        mode = 2'd0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [BANK_W-1:0] out_bank;
    logic [ROW_W-1:0]  out_row;
    logic [COL_W-1:0]  out_col;
    logic [1:0]        out_kind;

    int total = 0;
    int bad   = 0;
    int n_hit, n_miss, n_conf;

    logic             m_valid [NBANK];
    logic [ROW_W-1:0] m_row   [NBANK];

    always #5 clk = ~clk;

    bank_mapper #(.ADDR_W(ADDR_W), .NBANK(NBANK), .COL_W(COL_W)) dut (
        .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .out_valid(out_valid),
        .out_ready(out_ready), .out_bank(out_bank), .out_row(out_row),
        .out_col(out_col), .out_kind(out_kind)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ref_split(input logic [1:0] md, input logic [ADDR_W-1:0] a,
                             output int bk, output int rw, output int cl);
        if (md >= 2) begin
            bk = int'(a[15:14]); rw = int'(a[13:4]); cl = int'(a[3:0]);
        end else begin
            rw = int'(a[15:6]); cl = int'(a[5:2]);
            bk = int'(a[1:0]);
            if (md == 1) bk = bk ^ int'(a[7:6]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            m_valid[b] = 1'b0; m_row[b] = '0;
        end
        n_hit = 0; n_miss = 0; n_conf = 0;
    endtask

    // drives one request at a negedge, checks it at the next negedge
    task automatic issue(input logic [ADDR_W-1:0] a);
        int bk, rw, cl, kd;
        ref_split(mode, a, bk, rw, cl);
        if (!m_valid[bk])          kd = 0;
        else if (m_row[bk] == rw)  kd = 1;
        else                       kd = 2;
        m_valid[bk] = 1'b1; m_row[bk] = ROW_W'(rw);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_valid, "R8 out_valid one cycle after accept", int'(out_valid), 1);
        if (mode == 0)      check(int'(out_bank) == bk, "R1 spread bank", int'(out_bank), bk);
        else if (mode == 1) check(int'(out_bank) == bk, "R2 swizzle bank", int'(out_bank), bk);
        else                check(int'(out_bank) == bk, "R3 block bank", int'(out_bank), bk);
        check(int'(out_row) == rw && int'(out_col) == cl, "R1 R2 R3 row/col",
              int'(out_row) * 100 + int'(out_col), rw * 100 + cl);
        check(int'(out_kind) == kd, "R4 R5 R6 kind", int'(out_kind), kd);
        case (out_kind)
            2'd0: n_miss++;
            2'd1: n_hit++;
            2'd2: n_conf++;
            default: ;
        endcase
    endtask

    task automatic t_reset_state();
        do_reset();
        check(out_valid == 1'b0, "R7 out_valid low after reset", int'(out_valid), 0);
        check(req_ready == 1'b1, "R9 ready when empty", int'(req_ready), 1);
        mode = 2'd0;
        issue(16'd100);
        issue(16'd100);
        do_reset();
        issue(16'd100);
        check(out_kind == 2'd0, "R7 open rows cleared by reset", int'(out_kind), 0);
    endtask

    task automatic t_small_addrs();
        do_reset();
        mode = 2'd0;
        issue(16'd32);
        check(out_bank == 2'd0, "R1 addr 32", int'(out_bank), 0);
        issue(16'd33);
        check(out_bank == 2'd1, "R1 addr 33", int'(out_bank), 1);
        issue(16'd34);
        check(out_bank == 2'd2, "R1 addr 34", int'(out_bank), 2);
        check(out_bank[0] == 1'b0, "R1 addr 34 in 2-bank view", int'(out_bank[0]), 0);
        do_reset();
        mode = 2'd3;
        issue(16'h4000);
        check(out_bank == 2'd1 && out_row == '0, "R3 mode 3 block", int'(out_bank), 1);
    endtask

    task automatic t_sequential(input logic [1:0] md, input int em, input int eh, input int ec);
        do_reset();
        mode = md;
        for (int i = 0; i < 64; i++) issue(ADDR_W'(i));
        check(n_miss == em, "R6 sequential miss count", n_miss, em);
        check(n_hit  == eh, "R5 sequential hit count", n_hit, eh);
        check(n_conf == ec, "R5 sequential conflict count", n_conf, ec);
    endtask

    task automatic t_pingpong(input logic [1:0] md, input int em, input int eh, input int ec);
        do_reset();
        mode = md;
        for (int i = 0; i < 16; i++) issue((i % 2 == 0) ? 16'd0 : 16'd64);
        check(n_miss == em, "R6 ping-pong miss count", n_miss, em);
        check(n_hit  == eh, "R5 ping-pong hit count", n_hit, eh);
        check(n_conf == ec, "R5 ping-pong conflict count", n_conf, ec);
    endtask

    task automatic t_stride(input logic [1:0] md);
        do_reset();
        mode = md;
        for (int i = 0; i < 40; i++) issue(ADDR_W'(i * 321 + 7));
        check(n_miss + n_hit + n_conf == 40, "R4 stride classified", n_miss + n_hit + n_conf, 40);
    endtask

    task automatic t_backpressure();
        do_reset();
        mode = 2'd0;
        out_ready = 1'b0;
        req_valid = 1'b1; req_addr = 16'd5;
        @(negedge clk);
        check(out_valid && out_bank == 2'd1, "R9 first result", int'(out_bank), 1);
        req_addr = 16'd69;
        check(req_ready == 1'b0, "R9 not ready while stalled", int'(req_ready), 0);
        @(negedge clk);
        @(negedge clk);
        check(out_row == 10'd0 && out_kind == 2'd0, "R9 output holds", int'(out_row), 0);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(out_row == 10'd1 && out_kind == 2'd2, "R9 waiting request taken once",
              int'(out_row) * 10 + int'(out_kind), 12);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 drained", int'(out_valid), 0);
    endtask

    initial begin
        t_reset_state();
        t_small_addrs();
        t_sequential(2'd0, 4, 60, 0);
        t_sequential(2'd1, 4, 60, 0);
        t_sequential(2'd2, 1, 60, 3);
        t_pingpong(2'd0, 1, 0, 15);
        t_pingpong(2'd1, 2, 14, 0);
        t_pingpong(2'd2, 1, 0, 15);
        t_stride(2'd0);
        t_stride(2'd1);
        t_stride(2'd2);
        t_backpressure();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule